// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, based on the six destination bytes at the head of the frame. It holds a 48-bit station address and a 16-bit mode word. Each frame's destination is compared byte by byte against the station address and against the all-ones broadcast pattern, and its group bit is noted. One clock after the sixth byte, a single-cycle valid strobe carries the accept or reject decision.

Software sees four 32-bit registers through a plain read/write port: three address words and the mode word. The upper half of each register is reserved. Direct register access is allowed only while the controller's stop or suspend input is high. A separate initialization load port can fill any register at any time. Hard reset is an asynchronous active-low input. Soft reset is a synchronous pulse. The two resets and stop act on different fields in different ways.

Top module: `rx_dest_filter`

## Requirements
- R1: Register select 0 holds station address bits 15:0, select 1 bits 31:16, select 2 bits 47:32, and select 3 is the mode word. Only bits 15:0 of a write are stored, and bits 31:16 of every read are zero.
- R2: A direct write (`reg_wr`) takes effect only while `stop` or `susp` is high. Otherwise it is dropped and leaves the register unchanged.
- R3: While both `stop` and `susp` are low, `reg_rdata` is zero for every select.
- R4: The initialization port (`init_load`, `init_sel`, `init_data`) writes the selected register whatever the state of `stop` and `susp`. When it and a direct write occur in the same cycle, the initialization data is stored.
- R5: Hard reset sets the mode word to zero. Soft reset clears only mode bit 14. Stop changes no register. Neither reset changes the station address.
- R6: `dec_vld` is high for exactly one cycle, on the clock after the sixth destination byte. `rx_sof` together with `rx_byte_vld` marks byte 0 and restarts the count, even in the middle of a frame. Bytes that arrive with no frame open are ignored.
- R7: Destination byte k (k = 0..5, byte 0 first) is compared with station address bits 8k+7:8k.
- R8: A frame whose destination equals the station address, with bit 0 of byte 0 clear, is accepted when mode bit 13 is 0 and rejected when mode bit 13 is 1.
- R9: A frame sent to the broadcast address (all 48 bits set) is accepted unless mode bit 14 is 1.
- R10: A group frame (bit 0 of byte 0 set, not broadcast) is rejected unless promiscuous mode is on.
- R11: When mode bit 15 (promiscuous) is 1, every frame is accepted.
- R12: A unicast frame whose destination differs from the station address is rejected when mode bit 15 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Controller stopped; opens register access |
| susp | input | 1 | Controller suspended; opens register access |
| reg_wr | input | 1 | Direct register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Direct write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| init_load | input | 1 | Initialization load strobe |
| init_sel | input | 2 | Register select for the initialization load |
| init_data | input | 16 | Initialization load data |
| rx_sof | input | 1 | Marks byte 0 of a destination address |
| rx_byte_vld | input | 1 | Destination byte valid |
| rx_byte | input | 8 | Destination byte |
| dec_vld | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | 1 = accept frame, 0 = reject |

## Verification
The assertions check the following on every cycle:
- the register port reads zero while access is closed, and the reserved read bits are always zero;
- a dropped write leaves the mode word untouched;
- soft reset always clears the broadcast-disable bit;
- the decision strobe lasts a single cycle and always follows the sixth byte;
- promiscuous mode always gives an accept.

Other behaviours need the bench's scenarios:
- the byte order of the address comparison;
- the split between unicast, broadcast and group frames under each mode combination;
- the precedence of the initialization port;
- the address surviving a hard reset;
- a frame restarted in mid-address.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Mode word bit positions
  localparam int MODE_PROM  = 15;
  localparam int MODE_NOBC  = 14;
  localparam int MODE_NOPHY = 13;

  // Final accept decision from the per-frame match flags
  function automatic logic rxf_decide(input logic prom, input logic no_bc,
                                      input logic no_phy, input logic is_bc,
                                      input logic is_grp, input logic phy_hit);
    logic acc;
    if (prom)        acc = 1'b1;
    else if (is_bc)  acc = !no_bc;
    else if (is_grp) acc = 1'b0;
    else             acc = phy_hit && !no_phy;
    return acc;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int WORD_W     = 16,
  parameter int BUS_W      = 32,
  parameter int ADDR_WORDS = 3,
  parameter int SEL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic                          acc_en,
  input  logic                          reg_wr,
  input  logic [SEL_W-1:0]              reg_addr,
  input  logic [BUS_W-1:0]              reg_wdata,
  output logic [BUS_W-1:0]              reg_rdata,
  input  logic                          init_load,
  input  logic [SEL_W-1:0]              init_sel,
  input  logic [WORD_W-1:0]             init_data,
  output logic [ADDR_WORDS*WORD_W-1:0]  sta_addr,
  output logic [WORD_W-1:0]             mode_word
);
  import rxf_pkg::*;

  localparam logic [SEL_W-1:0] MODE_SEL = SEL_W'(ADDR_WORDS);

  logic              wr_ok;
  logic [WORD_W-1:0] adr_q [ADDR_WORDS];
  logic [WORD_W-1:0] rd_word;

  assign wr_ok = reg_wr && acc_en;

  // Station address words: no reset, loaded only by init port or direct write
  for (genvar i = 0; i < ADDR_WORDS; i++) begin : g_adr
    always_ff @(posedge clk) begin
      if (init_load && init_sel == SEL_W'(i))
        adr_q[i] <= init_data;
      else if (wr_ok && reg_addr == SEL_W'(i))
        adr_q[i] <= reg_wdata[WORD_W-1:0];
    end
    assign sta_addr[i*WORD_W +: WORD_W] = adr_q[i];
  end

  // Mode word: hard reset clears all, soft reset clears broadcast-disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_word <= '0;
    end else begin
      if (init_load && init_sel == MODE_SEL)
        mode_word <= init_data;
      else if (wr_ok && reg_addr == MODE_SEL)
        mode_word <= reg_wdata[WORD_W-1:0];
      if (soft_rst)
        mode_word[MODE_NOBC] <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (reg_addr == MODE_SEL) rd_word = mode_word;
    for (int i = 0; i < ADDR_WORDS; i++)
      if (reg_addr == SEL_W'(i)) rd_word = adr_q[i];
  end

  assign reg_rdata = acc_en ? {{(BUS_W-WORD_W){1'b0}}, rd_word} : '0;
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_sof,
  input  logic                    rx_byte_vld,
  input  logic [7:0]              rx_byte,
  input  logic [ADDR_BYTES*8-1:0] sta_addr,
  input  logic                    prom,
  input  logic                    no_bc,
  input  logic                    no_phy,
  output logic                    frame_last,
  output logic                    dec_vld,
  output logic                    dec_accept
);
  import rxf_pkg::*;

  localparam int CNT_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic [7:0]       sta_b [ADDR_BYTES];
  logic             open_q, phy_q, ones_q, grp_q;
  logic [CNT_W-1:0] cnt_q, idx;
  logic             take, phy_n, ones_n, grp_n;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
    assign sta_b[k] = sta_addr[k*8 +: 8];
  end

  assign take       = rx_byte_vld && (rx_sof || open_q);
  assign idx        = rx_sof ? '0 : cnt_q;
  assign phy_n      = (rx_sof || phy_q) && (rx_byte == sta_b[idx]);
  assign ones_n     = (rx_sof || ones_q) && (rx_byte == 8'hFF);
  assign grp_n      = rx_sof ? rx_byte[0] : grp_q;
  assign frame_last = take && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      cnt_q      <= '0;
      phy_q      <= 1'b0;
      ones_q     <= 1'b0;
      grp_q      <= 1'b0;
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_vld <= 1'b0;
      if (take) begin
        phy_q  <= phy_n;
        ones_q <= ones_n;
        grp_q  <= grp_n;
        if (frame_last) begin
          open_q     <= 1'b0;
          cnt_q      <= '0;
          dec_vld    <= 1'b1;
          dec_accept <= rxf_decide(prom, no_bc, no_phy, ones_n, grp_n, phy_n);
        end else begin
          open_q <= 1'b1;
          cnt_q  <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int WORD_W     = 16,
  parameter int BUS_W      = 32,
  parameter int ADDR_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              susp,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              init_load,
  input  logic [1:0]        init_sel,
  input  logic [WORD_W-1:0] init_data,
  input  logic              rx_sof,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  output logic              dec_vld,
  output logic              dec_accept
);
  import rxf_pkg::*;

  localparam int ADDR_BITS  = ADDR_BYTES * 8;
  localparam int ADDR_WORDS = ADDR_BITS / WORD_W;

  logic                 acc_en;
  logic [ADDR_BITS-1:0] sta_addr;
  logic [WORD_W-1:0]    mode_word;
  logic                 frame_last;

  assign acc_en = stop || susp;

  rxf_regs #(
    .WORD_W(WORD_W), .BUS_W(BUS_W), .ADDR_WORDS(ADDR_WORDS), .SEL_W(2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .acc_en(acc_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .init_load(init_load), .init_sel(init_sel),
    .init_data(init_data), .sta_addr(sta_addr), .mode_word(mode_word)
  );

  rxf_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .sta_addr(sta_addr),
    .prom(mode_word[MODE_PROM]), .no_bc(mode_word[MODE_NOBC]),
    .no_phy(mode_word[MODE_NOPHY]), .frame_last(frame_last),
    .dec_vld(dec_vld), .dec_accept(dec_accept)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int WORD_W = 16,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              stop,
  input logic              susp,
  input logic              reg_wr,
  input logic              init_load,
  input logic [BUS_W-1:0]  reg_rdata,
  input logic [WORD_W-1:0] mode_word,
  input logic              frame_last,
  input logic              dec_vld,
  input logic              dec_accept
);
  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BUS_W-1:WORD_W] == '0);

  // R2
  drop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !stop && !susp && !init_load && !soft_rst) |=> $stable(mode_word));

  // R3
  rd_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !susp) |-> reg_rdata == '0);

  // R5
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !mode_word[14]);

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  // R6
  after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> dec_vld);

  // R11
  prom_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(mode_word[15])) |-> dec_accept);
endmodule

bind rx_dest_filter rxf_chk #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .susp(susp),
  .reg_wr(reg_wr), .init_load(init_load), .reg_rdata(reg_rdata),
  .mode_word(mode_word), .frame_last(frame_last), .dec_vld(dec_vld),
  .dec_accept(dec_accept)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, stop = 1'b1, susp = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        init_load = 1'b0;
  logic [1:0]  init_sel = '0;
  logic [15:0] init_data = '0;
  logic        rx_sof = 1'b0, rx_byte_vld = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_vld, dec_accept;

  int checks = 0, errors = 0;
  logic [47:0] m_addr;
  logic [15:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .susp(susp),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .init_load(init_load), .init_sel(init_sel),
    .init_data(init_data), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_accept(dec_accept)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_acc(logic [15:0] md, logic [47:0] sa, logic [47:0] da);
    logic bc, grp;
    bc  = &da;
    grp = da[0];
    if (md[15]) return 1'b1;
    if (bc) return ~md[14];
    if (grp) return 1'b0;
    return (da == sa) & ~md[13];
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic load_addr(logic [47:0] a);
    wr(2'd0, {16'h0, a[15:0]});
    wr(2'd1, {16'h0, a[31:16]});
    wr(2'd2, {16'h0, a[47:32]});
    m_addr = a;
  endtask

  task automatic send(logic [47:0] da, int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_sof = (i == 0); rx_byte_vld = 1'b1; rx_byte = da[i*8 +: 8];
    end
    @(negedge clk);
    rx_sof = 1'b0; rx_byte_vld = 1'b0;
  endtask

  task automatic frame(string req, logic [47:0] da);
    send(da, 6);
    chk({req, " vld"}, {31'b0, dec_vld}, 32'd1);
    chk({req, " acc"}, {31'b0, dec_accept}, {31'b0, exp_acc(m_mode, m_addr, da)});
    @(negedge clk);
    chk("R6 pulse", {31'b0, dec_vld}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] da;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = 16'h0;
    rd("R5 reset mode", 2'd3, 32'h0);
    chk("R6 reset vld", {31'b0, dec_vld}, 32'd0);

    // R1 layout and reserved bits
    load_addr(48'hA1B2_C3D4_E5F6 & ~48'h1);
    wr(2'd0, 32'hFFFF_E5F6);
    rd("R1 word0", 2'd0, 32'h0000_E5F6);
    rd("R1 word1", 2'd1, 32'h0000_C3D4);
    rd("R1 word2", 2'd2, 32'h0000_A1B2);
    m_addr = 48'hA1B2_C3D4_E5F6;

    // R2 dropped write, R3 closed reads
    @(negedge clk); stop = 1'b0;
    wr(2'd1, 32'h0000_1111);
    wr(2'd3, 32'h0000_E000);
    rd("R3 closed read", 2'd2, 32'h0);
    @(negedge clk); stop = 1'b1;
    rd("R2 dropped addr", 2'd1, 32'h0000_C3D4);
    rd("R2 dropped mode", 2'd3, 32'h0);
    // R2 suspend opens access
    @(negedge clk); stop = 1'b0; susp = 1'b1;
    wr(2'd3, 32'h0000_0123);
    rd("R2 susp write", 2'd3, 32'h0000_0123);
    @(negedge clk); susp = 1'b0; stop = 1'b1;

    // R4 init port while closed, and precedence
    @(negedge clk); stop = 1'b0;
    init_load = 1'b1; init_sel = 2'd3; init_data = 16'h4000;
    @(negedge clk); init_load = 1'b0; stop = 1'b1;
    rd("R4 init closed", 2'd3, 32'h0000_4000);
    @(negedge clk);
    init_load = 1'b1; init_sel = 2'd3; init_data = 16'h2000;
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h0000_8000;
    @(negedge clk); init_load = 1'b0; reg_wr = 1'b0;
    rd("R4 init wins", 2'd3, 32'h0000_2000);

    // R5 soft reset and stop
    wr(2'd3, 32'h0000_E000);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd("R5 soft mode", 2'd3, 32'h0000_A000);
    rd("R5 soft addr", 2'd0, 32'h0000_E5F6);
    @(negedge clk); stop = 1'b0;
    @(negedge clk); stop = 1'b1;
    rd("R5 stop mode", 2'd3, 32'h0000_A000);
    // R5 hard reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd("R5 hard mode", 2'd3, 32'h0);
    rd("R5 hard addr", 2'd2, 32'h0000_A1B2);
    m_mode = 16'h0;

    // Directed filtering
    frame("R7 R8 own", m_addr);
    frame("R12 one byte off", m_addr ^ 48'h0100_0000_0000);
    frame("R7 swapped order", {m_addr[7:0], m_addr[15:8], m_addr[23:16],
                                m_addr[31:24], m_addr[39:32], m_addr[47:40]});
    frame("R9 bcast", 48'hFFFF_FFFF_FFFF);
    frame("R10 group", 48'h0000_0000_0001);
    wr(2'd3, 32'h0000_6000); m_mode = 16'h6000;
    frame("R8 phys off", m_addr);
    frame("R9 bcast off", 48'hFFFF_FFFF_FFFF);
    wr(2'd3, 32'h0000_E000); m_mode = 16'hE000;
    frame("R11 prom group", 48'h1234_5678_9A01);
    frame("R11 prom bcast", 48'hFFFF_FFFF_FFFF);
    wr(2'd3, 32'h0); m_mode = 16'h0;

    // R6 stray bytes, restart, trailing byte
    @(negedge clk); rx_byte_vld = 1'b1; rx_byte = m_addr[7:0];
    repeat (6) @(negedge clk);
    rx_byte_vld = 1'b0;
    @(negedge clk);
    chk("R6 no sof ignored", {31'b0, dec_vld}, 32'd0);
    send(48'hFFFF_FFFF_FFFF, 3);
    chk("R6 partial no vld", {31'b0, dec_vld}, 32'd0);
    frame("R6 restart", m_addr);
    @(negedge clk); rx_byte_vld = 1'b1; rx_byte = 8'h55;
    @(negedge clk); rx_byte_vld = 1'b0;
    @(negedge clk);
    chk("R6 trailing ignored", {31'b0, dec_vld}, 32'd0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0) begin
        load_addr({$urandom, $urandom} & 48'hFFFF_FFFF_FFFE);
        m_mode = 16'($urandom);
        wr(2'd3, {16'h0, m_mode});
      end
      case ($urandom % 4)
        0: da = m_addr;
        1: da = 48'hFFFF_FFFF_FFFF;
        2: da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
        default: da = ({$urandom, $urandom} | 48'h1) & 48'h7FFF_FFFF_FFFF;
      endcase
      frame("R8 R9 R10 R11 R12 random", da);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule